// File: doc/BRIEF.md
# SDRAM Clock-Enable and Command Front End

This block is the input stage of a single-data-rate SDRAM device model. On every rising clock edge it samples the clock-enable pin, the chip select and the three command strobes. It turns them into one registered command pulse. It also keeps a small state machine that decides whether the next edge is accepted at all. When clock-enable is seen low, the machine stops the device's internal clock from the following cycle. That stop is a plain clock suspend while any bank holds an open row, and a power-down when the bank logic reports all banks idle at that same edge.

The internal clock-enable output is meant to gate the burst counters and output registers that sit downstream, so their state stays frozen during a suspend. The decoded pulses drive the bank and mode logic. Exit from either stopped state is synchronous. Clock-enable seen high at one edge re-enables the internal clock, and the command sampled at the following edge is accepted.

The state machine has three states. ST_RUN means commands are accepted. ST_SUSP means clock suspend. ST_PDN means power-down. The transitions are:
- go-suspend: ST_RUN to ST_SUSP, taken when clock-enable is low and not all banks are idle.
- go-powerdown: ST_RUN to ST_PDN, taken when clock-enable is low and all banks are idle.
- hold: the machine stays in ST_SUSP or ST_PDN while clock-enable stays low.
- wake: ST_SUSP or ST_PDN returns to ST_RUN when clock-enable is high.
- run: the machine stays in ST_RUN while clock-enable is high.

Top module: `sdram_cke_front`

## Requirements
- R1: Inputs are sampled only on the rising clock edge. A command's pulse appears just after the edge that sampled it, is registered, and lasts one cycle.
- R2: The machine accepts an edge when it was in ST_RUN before that edge. On each accepted edge exactly one pulse fires. With cs_n low, {ras_n,cas_n,we_n} decodes as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set.
- R3: When cs_n is high on an accepted edge, the nop pulse fires whatever ras_n, cas_n and we_n carry.
- R4: With cs_n low, 111 on {ras_n,cas_n,we_n} gives the nop pulse. So does 110, since it is not one of the decoded commands.
- R5: Clock-enable is sampled low in ST_RUN while all_idle is low. From that edge the suspend flag is high and clk_en is low, and this holds while clock-enable stays low.
- R6: When the machine was in ST_SUSP or ST_PDN before an edge, no pulse fires, whatever the command pins carry.
- R7: Clock-enable is sampled low in ST_RUN while all_idle is high. From that edge the power-down flag is high. It holds while clock-enable stays low, and all_idle has no effect on it meanwhile.
- R8: Clock-enable sampled high at an edge sets clk_en high after that edge. The command at that same edge is not accepted when the machine was stopped before it. The command at the next edge is accepted.
- R9: The suspend and power-down flags are never high together, and clk_en is high exactly when neither flag is high.
- R10: While rst_n is low the machine is in ST_RUN: clk_en is high and every flag and pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock-enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| all_idle | input | 1 | High when no bank holds an open row |
| clk_en | output | 1 | Internal clock enable for downstream state |
| suspend | output | 1 | Clock suspend in effect |
| pdown | output | 1 | Power-down in effect |
| stb_act | output | 1 | Activate pulse |
| stb_rd | output | 1 | Read pulse |
| stb_wr | output | 1 | Write pulse |
| stb_pre | output | 1 | Precharge pulse |
| stb_ref | output | 1 | Refresh pulse |
| stb_mrs | output | 1 | Mode set pulse |
| stb_nop | output | 1 | No-operation or deselect pulse |

## Verification
Two functions can fall on the same edge. The edge where clock-enable is first seen low still accepts its command, and that same edge also decides between suspend and power-down. The bench drives a real command together with a falling clock-enable under both values of all_idle. It then expects the command pulse and the new stopped flag to appear together just after that edge. On the wake edge it checks the reverse case: the command there must be dropped while clk_en rises, and a behavioural reference model compares every output on every clock of a long randomized run.

// File: rtl/sdcke_pkg.sv
package sdcke_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SUSP,
        ST_PDN
    } cke_state_t;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6
    } cmd_t;

    localparam int NUM_CMD = 7;

endpackage

// File: rtl/sdcke_cmd_decode.sv
module sdcke_cmd_decode
    import sdcke_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_t cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_NOP;              // decoder disabled: deselect (R3)
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_NOP; // 111 and 110 (R4)
            endcase
        end
    end

endmodule

// File: rtl/sdcke_fsm.sv
module sdcke_fsm
    import sdcke_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic all_idle,
    output logic accept,
    output logic clk_en,
    output logic suspend,
    output logic pdown
);

    cke_state_t state_q;
    cke_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (!cke) state_d = all_idle ? ST_PDN : ST_SUSP;
            end
            ST_SUSP: begin
                if (cke) state_d = ST_RUN;
            end
            ST_PDN: begin
                if (cke) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        accept  = 1'b0;
        clk_en  = 1'b0;
        suspend = 1'b0;
        pdown   = 1'b0;
        unique case (state_q)
            ST_RUN:  begin accept = 1'b1; clk_en = 1'b1; end
            ST_SUSP: suspend = 1'b1;
            ST_PDN:  pdown   = 1'b1;
            default: begin accept = 1'b1; clk_en = 1'b1; end
        endcase
    end

    p_susp_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !cke && !all_idle) |=> suspend);

    p_pdn_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !cke && all_idle) |=> pdown);

    p_pdn_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pdown && !cke) |=> pdown);

    p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && cke) |=> clk_en);

    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(suspend && pdown) && (clk_en == !(suspend || pdown)));

endmodule

// File: rtl/sdram_cke_front.sv
module sdram_cke_front
    import sdcke_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic all_idle,
    output logic clk_en,
    output logic suspend,
    output logic pdown,
    output logic stb_act,
    output logic stb_rd,
    output logic stb_wr,
    output logic stb_pre,
    output logic stb_ref,
    output logic stb_mrs,
    output logic stb_nop
);

    localparam logic [NUM_CMD-1:0] ONE = {{(NUM_CMD-1){1'b0}}, 1'b1};

    logic               accept;
    cmd_t               cmd;
    logic [NUM_CMD-1:0] stb_q;

    sdcke_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke      (cke),
        .all_idle (all_idle),
        .accept   (accept),
        .clk_en   (clk_en),
        .suspend  (suspend),
        .pdown    (pdown)
    );

    sdcke_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    // One registered pulse per accepted edge (R1, R2); none while stopped (R6)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stb_q <= '0;
        else if (accept) stb_q <= ONE << cmd;
        else             stb_q <= '0;
    end

    assign stb_nop = stb_q[CMD_NOP];
    assign stb_act = stb_q[CMD_ACT];
    assign stb_rd  = stb_q[CMD_RD];
    assign stb_wr  = stb_q[CMD_WR];
    assign stb_pre = stb_q[CMD_PRE];
    assign stb_ref = stb_q[CMD_REF];
    assign stb_mrs = stb_q[CMD_MRS];

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> ($countones(stb_q) == 1));

    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> (stb_q == '0));

    p_desel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cs_n) |=> stb_nop);

endmodule

// File: tb/sdram_cke_front_tb_top.sv
module sdram_cke_front_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic all_idle = 1'b0;
    logic clk_en, suspend, pdown;
    logic stb_act, stb_rd, stb_wr, stb_pre, stb_ref, stb_mrs, stb_nop;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk; // 50 MHz

    sdram_cke_front dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .all_idle(all_idle), .clk_en(clk_en),
        .suspend(suspend), .pdown(pdown), .stb_act(stb_act), .stb_rd(stb_rd),
        .stb_wr(stb_wr), .stb_pre(stb_pre), .stb_ref(stb_ref),
        .stb_mrs(stb_mrs), .stb_nop(stb_nop)
    );

    // Reference model. Mode: 0 running, 1 suspended, 2 powered down.
    // Pulse bit order: 6 mrs, 5 ref, 4 pre, 3 wr, 2 rd, 1 act, 0 nop
    int         m_mode = 0;
    logic [6:0] m_stb  = '0;
    string      m_tag  = "R10";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0;
            m_stb  = '0;
            m_tag  = "R10";
        end else begin
            if (m_mode != 0) begin
                m_stb = '0;
                m_tag = "R6";
            end else if (cs_n) begin
                m_stb = 7'b0000001;
                m_tag = "R3";
            end else begin
                case ({ras_n, cas_n, we_n})
                    3'b011:  begin m_stb = 7'b0000010; m_tag = "R2"; end
                    3'b101:  begin m_stb = 7'b0000100; m_tag = "R2"; end
                    3'b100:  begin m_stb = 7'b0001000; m_tag = "R2"; end
                    3'b010:  begin m_stb = 7'b0010000; m_tag = "R2"; end
                    3'b001:  begin m_stb = 7'b0100000; m_tag = "R2"; end
                    3'b000:  begin m_stb = 7'b1000000; m_tag = "R2"; end
                    default: begin m_stb = 7'b0000001; m_tag = "R4"; end
                endcase
            end
            if (cke)              m_mode = 0;
            else if (m_mode == 0) m_mode = all_idle ? 2 : 1;
        end
    end

    task automatic chk(input string tag, input logic [6:0] got, input logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [6:0] got;
        got = {stb_mrs, stb_ref, stb_pre, stb_wr, stb_rd, stb_act, stb_nop};
        chk(m_tag, got, m_stb);
        chk("R8 clk_en", {6'd0, clk_en}, {6'd0, m_mode == 0});
        chk("R5 suspend", {6'd0, suspend}, {6'd0, m_mode == 1});
        chk("R7 pdown", {6'd0, pdown}, {6'd0, m_mode == 2});
        chk("R9 flags", {5'd0, suspend && pdown, clk_en != !(suspend || pdown)}, 7'd0);
    endtask

    // drive at negedge, run one edge, compare at next negedge
    task automatic step(input logic k, input logic [3:0] c, input logic idle);
        cke = k; {cs_n, ras_n, cas_n, we_n} = c; all_idle = idle;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset", {clk_en, suspend, pdown, stb_act, stb_rd, stb_nop, stb_mrs},
            7'b1000000);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();
        // R1: pulse is not visible before the sampling edge
        cke = 1; {cs_n, ras_n, cas_n, we_n} = 4'b0011; all_idle = 0;
        #5;
        chk("R1 pre-edge", {6'd0, stb_act}, 7'd0);
        @(negedge clk);
        compare_all();
        // R2, R4: every code with cs_n low; R3: deselect with other pins low
        for (int i = 0; i < 8; i++) step(1, {1'b0, 3'(i)}, 0);
        step(1, 4'b1000, 0);
        step(1, 4'b1011, 1);
        // R5: clock-enable falls with an ACT, banks open -> suspend, same edge
        step(0, 4'b0011, 0);
        step(0, 4'b0101, 1);   // R6: ignored while suspended, all_idle too
        step(0, 4'b0000, 0);
        // R8: wake edge drops its command, next edge accepts
        step(1, 4'b0100, 0);
        step(1, 4'b0101, 0);
        // R7: fall with all banks idle, REF on same edge -> powerdown
        step(0, 4'b0001, 1);
        step(0, 4'b0011, 0);   // R7 hold despite all_idle low; R6 no pulse
        step(0, 4'b0010, 1);
        step(1, 4'b0000, 1);   // R8 wake
        step(1, 4'b0000, 1);
        // randomized run
        for (int n = 0; n < 4000; n++)
            step(($urandom % 5) != 0, 4'($urandom), 1'($urandom));
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule